// File: doc/BRIEF.md
# Queued Serial Port Configuration and Status Registers

This block is the register bank that a CPU uses to configure a queued serial transfer engine. It holds four control words and one status word. Each register sits at its own word address on a simple synchronous bus. The engine reads the committed configuration from dedicated output ports. It can drop the run-enable bit, and it can raise status flags.

Three of the control words take effect at once when written. While the engine runs, writing a changed value to one of them can corrupt a transfer in progress, so such writes latch a sticky disturbance error. The queue-control word is different: CPU writes land in a hidden holding copy. The holding copy is promoted to the live word only when the engine reports the end of a serial transfer, or on the following clock if the engine is stopped. Each promotion produces a single-cycle restart strobe that carries the queue start pointer. The status word is write-one-to-clear.

The queue-control path is a three-state machine. In IDLE nothing is pending. A CPU write moves it to HOLD. HOLD moves to FIRE when the engine is disabled or signals end of transfer. FIRE lasts one cycle and emits the restart strobe. It then returns to IDLE, or goes back to HOLD if another write arrives in that cycle.

Top module: `qspi_csr_bank`

## Requirements
- R1: After reset, all four control words, the holding copy, the status flags and the disturbance error are zero. The engine is disabled and no restart strobe is active.
- R2: A CPU write to address 0 (mode), 1 (run) or 3 (delay) appears on the matching configuration output after the clock edge that takes the write.
- R3: Run-enable is bit 15 of the run word. An engine stop request clears only that bit, and it wins over a CPU write that sets the bit in the same cycle.
- R4: While enabled, a write of a changed value to address 0 or 3, or a change to bits 14:0 of the run word, sets the disturbance error. The error stays set until reset. Writes made while disabled never set it.
- R5: While enabled, writing the value a non-buffered word already holds leaves the disturbance error unchanged.
- R6: While enabled, a write to address 2 does not change the queue-control output or its read-back. The value commits on the clock edge where end-of-transfer is high.
- R7: A commit raises the restart strobe for exactly one cycle. The restart pointer equals bits 3:0 of the committed queue-control word.
- R8: While disabled, a pending queue-control write commits at the clock edge after the write.
- R9: When several queue-control writes arrive before one commit, the last one wins, and that commit produces one strobe. A write in the commit cycle is the value committed.
- R10: An engine set request raises the status flag in bits 3:0. A CPU write to address 4 clears the flags written as 1. A set request in the same cycle wins.
- R11: Read data is registered. It shows, one cycle later, the addressed word as it was before that edge: 0 mode, 1 run, 2 live queue control, 3 delay, 4 flags in bits 3:0, and zero at addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| eng_stop | input | 1 | Engine request to clear run-enable |
| eng_xfer_done | input | 1 | Engine end-of-transfer marker |
| eng_flag_set | input | 4 | Engine status set requests |
| cfg_mode | output | 16 | Committed mode word |
| cfg_run | output | 16 | Committed run word |
| cfg_queue | output | 16 | Live queue-control word |
| cfg_delay | output | 16 | Committed delay word |
| eng_enable | output | 1 | Run-enable bit |
| q_restart | output | 1 | One-cycle queue restart strobe |
| q_restart_ptr | output | 4 | Queue start pointer |
| stat_flags | output | 4 | Status flags |
| cfg_disturbed | output | 1 | Sticky disturbance error |

## Verification
Queue-control writes are applied in four conditions: while stopped, while running with no end-of-transfer, as bursts before a single end-of-transfer, and in the same cycle as end-of-transfer. Together these separate an immediate commit, a held commit, the last-writer-wins rule and the bypass of a same-cycle write. Non-buffered writes are tried with equal values, changed values, and changes to the enable bit alone, while both running and stopped. This separates a real disturbance from a harmless rewrite. A long random phase mixes all inputs, including stop requests and set requests that collide with clears.

// File: rtl/qcsr_pkg.sv
package qcsr_pkg;
    parameter int QC_DW     = 16;
    parameter int QC_AW     = 3;
    parameter int QC_NFLAG  = 4;
    parameter int QC_PTRW   = 4;
    parameter int QC_EN_BIT = 15;

    parameter int QC_A_MODE  = 0;
    parameter int QC_A_RUN   = 1;
    parameter int QC_A_QUEUE = 2;
    parameter int QC_A_DELAY = 3;
    parameter int QC_A_STAT  = 4;

    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_HOLD = 2'd1,
        Q_FIRE = 2'd2
    } q_state_t;
endpackage

// File: rtl/qcsr_plain_reg.sv
module qcsr_plain_reg #(
    parameter int DW = 16,
    parameter logic [DW-1:0] CMP_MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] hw_clr,
    output logic [DW-1:0] value,
    output logic          diff_wr
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = (wr_en ? wr_data : value) & ~hw_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else        value <= nxt;
    end

    // a write that changes any compared bit
    assign diff_wr = wr_en && (((wr_data ^ value) & CMP_MASK) != '0);

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hw_clr == '0) |=> value == $past(wr_data)); // R2
    AST_HW_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr != '0) |=> ((value & $past(hw_clr)) == '0)); // R3
endmodule

// File: rtl/qcsr_queue_shadow.sv
module qcsr_queue_shadow import qcsr_pkg::*; #(
    parameter int DW   = QC_DW,
    parameter int PTRW = QC_PTRW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            eng_en,
    input  logic            xfer_done,
    output logic [DW-1:0]   active,
    output logic            restart,
    output logic [PTRW-1:0] restart_ptr
);
    q_state_t      st_q, st_d;
    logic [DW-1:0] shadow_q, active_q;
    logic          commit;

    assign commit = (st_q == Q_HOLD) && (!eng_en || xfer_done);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_IDLE:  if (wr_en) st_d = Q_HOLD;
            Q_HOLD:  if (commit) st_d = Q_FIRE;
            Q_FIRE:  st_d = wr_en ? Q_HOLD : Q_IDLE;
            default: st_d = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= Q_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en)  shadow_q <= wr_data;
            if (commit) active_q <= wr_en ? wr_data : shadow_q;
        end
    end

    always_comb begin
        active      = active_q;
        restart     = (st_q == Q_FIRE);
        restart_ptr = active_q[PTRW-1:0];
    end

    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart); // R9
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_HOLD && eng_en && !xfer_done) |=> $stable(active_q)); // R6
    AST_IDLE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_HOLD && !eng_en) |=> restart); // R8
endmodule

// File: rtl/qcsr_status.sv
module qcsr_status #(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_req,
    input  logic             clr_wr,
    input  logic [NFLAG-1:0] clr_bits,
    output logic [NFLAG-1:0] flags
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[g] <= 1'b0;
            else        flags[g] <= set_req[g] | (flags[g] & ~(clr_wr & clr_bits[g]));
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req != '0) |=> ((flags & $past(set_req)) == $past(set_req))); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_req == '0) |=> ((flags & $past(clr_bits)) == '0)); // R10
endmodule

// File: rtl/qspi_csr_bank.sv
module qspi_csr_bank import qcsr_pkg::*; #(
    parameter int DW     = QC_DW,
    parameter int AW     = QC_AW,
    parameter int NFLAG  = QC_NFLAG,
    parameter int PTRW   = QC_PTRW,
    parameter int EN_BIT = QC_EN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             eng_stop,
    input  logic             eng_xfer_done,
    input  logic [NFLAG-1:0] eng_flag_set,
    output logic [DW-1:0]    cfg_mode,
    output logic [DW-1:0]    cfg_run,
    output logic [DW-1:0]    cfg_queue,
    output logic [DW-1:0]    cfg_delay,
    output logic             eng_enable,
    output logic             q_restart,
    output logic [PTRW-1:0]  q_restart_ptr,
    output logic [NFLAG-1:0] stat_flags,
    output logic             cfg_disturbed
);
    localparam int NPLAIN = 3;
    localparam logic [DW-1:0] EN_MASK = DW'(1) << EN_BIT;

    logic [DW-1:0]     plain_val [NPLAIN];
    logic [NPLAIN-1:0] plain_diff;
    logic [DW-1:0]     rd_mux;
    logic              dist_q;

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        localparam int PA = (g == 0) ? QC_A_MODE : ((g == 1) ? QC_A_RUN : QC_A_DELAY);
        localparam logic [DW-1:0] CMPM = (g == 1) ? ~EN_MASK : {DW{1'b1}};
        localparam logic [DW-1:0] CLRM = (g == 1) ? EN_MASK : {DW{1'b0}};
        qcsr_plain_reg #(.DW(DW), .CMP_MASK(CMPM)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && (bus_addr == AW'(PA))),
            .wr_data (bus_wdata),
            .hw_clr  (eng_stop ? CLRM : {DW{1'b0}}),
            .value   (plain_val[g]),
            .diff_wr (plain_diff[g])
        );
    end

    assign cfg_mode   = plain_val[0];
    assign cfg_run    = plain_val[1];
    assign cfg_delay  = plain_val[2];
    assign eng_enable = plain_val[1][EN_BIT];

    qcsr_queue_shadow #(.DW(DW), .PTRW(PTRW)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_we && (bus_addr == AW'(QC_A_QUEUE))),
        .wr_data     (bus_wdata),
        .eng_en      (eng_enable),
        .xfer_done   (eng_xfer_done),
        .active      (cfg_queue),
        .restart     (q_restart),
        .restart_ptr (q_restart_ptr)
    );

    qcsr_status #(.NFLAG(NFLAG)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (eng_flag_set),
        .clr_wr   (bus_we && (bus_addr == AW'(QC_A_STAT))),
        .clr_bits (bus_wdata[NFLAG-1:0]),
        .flags    (stat_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dist_q <= 1'b0;
        else        dist_q <= dist_q | (eng_enable && (plain_diff != '0));
    end
    assign cfg_disturbed = dist_q;

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            AW'(QC_A_MODE):  rd_mux = cfg_mode;
            AW'(QC_A_RUN):   rd_mux = cfg_run;
            AW'(QC_A_QUEUE): rd_mux = cfg_queue;
            AW'(QC_A_DELAY): rd_mux = cfg_delay;
            AW'(QC_A_STAT):  rd_mux = {{(DW-NFLAG){1'b0}}, stat_flags};
            default:         rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop |=> !eng_enable); // R3
    AST_DISTURB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_disturbed |=> cfg_disturbed); // R4
    AST_SAME_VALUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_enable && bus_we && bus_addr == AW'(QC_A_MODE) && bus_wdata == cfg_mode
         && !cfg_disturbed) |=> !cfg_disturbed); // R5
endmodule

// File: tb/sim_qspi_csr_bank.sv
module sim_qspi_csr_bank;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [2:0]  addr;
    logic        we;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        stop, xfer;
    logic [3:0]  fset;
    logic [15:0] o_mode, o_run, o_queue, o_delay;
    logic        o_en, o_rst;
    logic [3:0]  o_ptr, o_flags;
    logic        o_dist;

    int total = 0;
    int bad   = 0;

    qspi_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .eng_stop(stop), .eng_xfer_done(xfer), .eng_flag_set(fset),
        .cfg_mode(o_mode), .cfg_run(o_run), .cfg_queue(o_queue), .cfg_delay(o_delay),
        .eng_enable(o_en), .q_restart(o_rst), .q_restart_ptr(o_ptr),
        .stat_flags(o_flags), .cfg_disturbed(o_dist)
    );

    // behavioural reference
    logic [15:0] m_mode, m_run, m_queue, m_delay, m_shadow, m_rd, rd_next;
    logic        m_pend, m_fire, m_dist, en_old, wq;
    logic [3:0]  m_flags;

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_queue = 0; m_delay = 0; m_shadow = 0; m_rd = 0;
            m_pend = 0; m_fire = 0; m_dist = 0; m_flags = 0;
        end else begin
            en_old = m_run[15];
            case (addr)
                3'd0: rd_next = m_mode;
                3'd1: rd_next = m_run;
                3'd2: rd_next = m_queue;
                3'd3: rd_next = m_delay;
                3'd4: rd_next = {12'h000, m_flags};
                default: rd_next = 16'h0000;
            endcase
            if (en_old && we && ((addr == 0 && wdata != m_mode) || (addr == 3 && wdata != m_delay) ||
                (addr == 1 && ((wdata ^ m_run) & 16'h7fff) != 0)))
                m_dist = 1;
            wq = we && addr == 2;
            if (m_pend && (!en_old || xfer)) begin
                m_queue = wq ? wdata : m_shadow;
                m_fire  = 1;
                m_pend  = 0;
            end else begin
                m_fire = 0;
                if (wq) m_pend = 1;
            end
            if (wq) m_shadow = wdata;
            if (we && addr == 0) m_mode  = wdata;
            if (we && addr == 3) m_delay = wdata;
            if (we && addr == 1) m_run   = wdata;
            if (stop) m_run[15] = 0;
            m_flags = (m_flags & ~((we && addr == 4) ? wdata[3:0] : 4'h0)) | fset;
            m_rd = rd_next;
        end
        #2;
        chk("R2", "mode", o_mode, m_mode);
        chk("R2", "run", o_run, m_run);
        chk("R2", "delay", o_delay, m_delay);
        chk("R6/R9", "queue", o_queue, m_queue);
        chk("R3", "enable", {15'b0, o_en}, {15'b0, m_run[15]});
        chk("R7/R8", "restart", {15'b0, o_rst}, {15'b0, m_fire});
        chk("R7", "ptr", {12'b0, o_ptr}, {12'b0, m_queue[3:0]});
        chk("R10", "flags", {12'b0, o_flags}, {12'b0, m_flags});
        chk("R4/R5", "disturbed", {15'b0, o_dist}, {15'b0, m_dist});
        chk("R11", "rdata", rdata, m_rd);
    end

    task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d,
                       input logic stp, input logic xd, input logic [3:0] st);
        @(negedge clk);
        we = w; addr = a; wdata = d; stop = stp; xfer = xd; fset = st;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'd0, 16'h0, 0, 0, 4'h0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; we = 0; addr = 0; wdata = 0; stop = 0; xfer = 0; fset = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "reset enable", {15'b0, o_en}, 16'h0);
        chk("R1", "reset queue", o_queue, 16'h0);
        chk("R1", "reset disturbed", {15'b0, o_dist}, 16'h0);
        chk("R1", "reset restart", {15'b0, o_rst}, 16'h0);
        rst_n = 1;
        idle(2);
        // R2, R11: plain writes while stopped, then read every address
        cyc(1, 3'd0, 16'h1234, 0, 0, 0);
        cyc(1, 3'd3, 16'hbeef, 0, 0, 0);
        cyc(1, 3'd1, 16'h0042, 0, 0, 0);
        for (int a = 0; a < 8; a++) cyc(0, 3'(a), 16'h0, 0, 0, 0);
        // R8: queue write while stopped commits next clock
        cyc(1, 3'd2, 16'h00a5, 0, 0, 0);
        idle(3);
        // enable, R5 same-value rewrites, R4 enable-only change is harmless
        cyc(1, 3'd1, 16'h8042, 0, 0, 0);
        cyc(1, 3'd0, 16'h1234, 0, 0, 0);
        cyc(1, 3'd3, 16'hbeef, 0, 0, 0);
        cyc(1, 3'd1, 16'h8042, 0, 0, 0);
        idle(2);
        // R6, R9: several queue writes held until end of transfer
        cyc(1, 3'd2, 16'h0103, 0, 0, 0);
        cyc(1, 3'd2, 16'h0207, 0, 0, 0);
        cyc(0, 3'd2, 16'h0, 0, 0, 0);
        cyc(1, 3'd2, 16'h030c, 0, 0, 0);
        idle(3);
        cyc(0, 3'd2, 16'h0, 0, 1, 0);
        idle(3);
        // R9: write in same cycle as end of transfer, then write during strobe
        cyc(1, 3'd2, 16'h0401, 0, 0, 0);
        cyc(1, 3'd2, 16'h050e, 0, 1, 0);
        cyc(1, 3'd2, 16'h0609, 0, 0, 0);
        idle(2);
        cyc(0, 3'd0, 16'h0, 0, 1, 0);
        idle(2);
        // R4: changed value while enabled
        cyc(1, 3'd3, 16'h0001, 0, 0, 0);
        idle(3);
        // R3: stop, then stop colliding with a CPU enable
        cyc(0, 3'd1, 16'h0, 1, 0, 0);
        cyc(1, 3'd1, 16'h8042, 1, 0, 0);
        idle(2);
        // R10: set, clear, set colliding with clear
        cyc(0, 3'd4, 16'h0, 0, 0, 4'hf);
        cyc(1, 3'd4, 16'h0005, 0, 0, 0);
        cyc(1, 3'd4, 16'h000a, 0, 0, 4'h2);
        cyc(0, 3'd4, 16'h0, 0, 0, 0);
        idle(2);
        // mixed random phase covering all requirements
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  ra;
            logic [15:0] rd;
            ra = 3'($urandom % 8);
            case (ra)
                3'd0: rd = m_mode;
                3'd1: rd = m_run;
                3'd3: rd = m_delay;
                default: rd = 16'($urandom);
            endcase
            if ($urandom % 2 == 0) rd = 16'($urandom);
            if (ra == 3'd1 && $urandom % 3 == 0) rd[15] = 1'b1;
            cyc(($urandom % 3) == 0, ra, rd, ($urandom % 23) == 0, ($urandom % 5) == 0,
                (($urandom % 9) == 0) ? 4'($urandom) : 4'h0);
        end
        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule